// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Bank with Pin Takeover

This block controls four bidirectional pads from a byte-wide register bus. Software sets a drive value and a drive enable for each pin, and it can switch off the weak pulldown on each pin. It reads the pin levels back through a synchronized input register. The block produces a level, a drive enable and a pulldown enable for each pin and passes them to the tri-state pad cells, which sit outside the block.

A control register holds two takeover bits. With the serial bit set, pin 2 drives the serial transmit value and pin 3 becomes the serial receive input. With the interrupt bit set, pins 0 and 1 become listen-only inputs. Their synchronized levels go to the two external interrupt lines. The takeover changes only what the pads do. The software-visible registers keep their values.

Top module: `gpio_alt_bank`

## Requirements
- R1: While reset is asserted and after it is released, every register reads 00h, `pad_oe` is 0000b, `pad_pd_en` is 1111b and `ext_irq` is 00b.
- R2: A write takes effect on the clock edge that samples the write strobe. The offsets are 20h (drive value), 21h (drive enable), 25h (pulldown disable) and 05h (control: bit 1 is serial takeover, bit 0 is interrupt takeover). Reads return bits 3..0 of the drive value, drive enable and pulldown-disable registers, and bits 1..0 of the control register. All higher bits read as zero.
- R3: With no takeover active, `pad_oe[i]` equals drive-enable bit i. `pad_out[i]` always equals drive-value bit i, except for pin 2 under serial takeover.
- R4: `pad_pd_en[i]` is the inverse of pulldown-disable bit i.
- R5: A read of offset 22h returns the pad levels in bits 3..0, delayed by a two-flop synchronizer. A write to 22h changes no register.
- R6: A read returns data in the same cycle as the read strobe. Unmapped offsets, and any cycle without a read strobe, return 00h.
- R7: With the serial takeover bit set, `pad_oe[2]`=1 and `pad_out[2]`=`ser_tx`, `pad_oe[3]`=0, and `ser_rx` is the synchronized level of pin 3. With the bit clear, `ser_rx` is 1.
- R8: With the interrupt takeover bit set, `pad_oe[1:0]`=00b and `ext_irq[i]` is the synchronized level of pin i. With the bit clear, `ext_irq` is 00b.
- R9: A takeover never alters the stored drive value or drive enable. Both read back unchanged while a takeover is active and after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset within the system page |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| pad_in | input | 4 | Pad levels seen at the pins |
| pad_out | output | 4 | Per-pin drive level |
| pad_oe | output | 4 | Per-pin driver enable (0 = tri-state) |
| pad_pd_en | output | 4 | Per-pin pulldown enable |
| ser_tx | input | 1 | Serial transmit value from the core |
| ser_rx | output | 1 | Serial receive value to the core |
| ext_irq | output | 2 | External interrupt inputs to the core |

## Verification
A register write and an active pin takeover can occur in the same cycle. One test writes the drive value and drive enable while serial and interrupt takeover hold pins 0 to 3. The test judges the pads against the override, then reads both registers back to confirm that the writes landed. A second overlap is a pad level change during an input-register read. The bench changes `pad_in` with takeover active and waits exactly two edges. It then expects the new level at offset 22h and on `ser_rx` or `ext_irq` together.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NPINS = 4;
  localparam int DW    = 8;
  localparam int AW    = 8;

  localparam logic [AW-1:0] OFS_CTRL = 8'h05;
  localparam logic [AW-1:0] OFS_DRV  = 8'h20;
  localparam logic [AW-1:0] OFS_DEN  = 8'h21;
  localparam logic [AW-1:0] OFS_LVL  = 8'h22;
  localparam logic [AW-1:0] OFS_PDD  = 8'h25;

  localparam int TX_PIN    = 2;
  localparam int RX_PIN    = 3;
  localparam int CTL_IRQ   = 0;
  localparam int CTL_SER   = 1;
  localparam int CTL_BITS  = 2;

  // Widen a narrow field onto the data bus with zero fill.
  function automatic logic [DW-1:0] pad_field(input logic [NPINS-1:0] v);
    return {{(DW-NPINS){1'b0}}, v};
  endfunction

  // Mask of pins whose driver a takeover switches off.
  function automatic logic [NPINS-1:0] forced_off(input logic ser, input logic irq);
    logic [NPINS-1:0] m;
    m = '0;
    m[RX_PIN] = ser;
    m[0]      = irq;
    m[1]      = irq;
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                wr,
  input  logic                rd,
  input  logic [DW-1:0]       wdata,
  input  logic [NPINS-1:0]    lvl_sync,
  output logic [DW-1:0]       rdata,
  output logic [NPINS-1:0]    drv_q,
  output logic [NPINS-1:0]    den_q,
  output logic [NPINS-1:0]    pdd_q,
  output logic [CTL_BITS-1:0] ctl_q
);
  logic hit_drv, hit_den, hit_pdd, hit_ctl, hit_lvl;

  assign hit_drv = (addr == OFS_DRV);
  assign hit_den = (addr == OFS_DEN);
  assign hit_pdd = (addr == OFS_PDD);
  assign hit_ctl = (addr == OFS_CTRL);
  assign hit_lvl = (addr == OFS_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= '0;
      den_q <= '0;
      pdd_q <= '0;
      ctl_q <= '0;
    end else if (wr) begin
      if (hit_drv) drv_q <= wdata[NPINS-1:0];
      if (hit_den) den_q <= wdata[NPINS-1:0];
      if (hit_pdd) pdd_q <= wdata[NPINS-1:0];
      if (hit_ctl) ctl_q <= wdata[CTL_BITS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (1'b1)
        hit_drv: rdata = pad_field(drv_q);
        hit_den: rdata = pad_field(den_q);
        hit_pdd: rdata = pad_field(pdd_q);
        hit_lvl: rdata = pad_field(lvl_sync);
        hit_ctl: rdata = {{(DW-CTL_BITS){1'b0}}, ctl_q};
        default: rdata = '0;
      endcase
    end
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NPINS] == '0);

  assert_level_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_lvl) |=> ($stable(drv_q) && $stable(den_q) && $stable(pdd_q) && $stable(ctl_q)));

  assert_idle_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> rdata == '0);
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_bank_pkg::*;
(
  input  logic [NPINS-1:0]    drv_q,
  input  logic [NPINS-1:0]    den_q,
  input  logic [NPINS-1:0]    pdd_q,
  input  logic [CTL_BITS-1:0] ctl_q,
  input  logic [NPINS-1:0]    lvl_sync,
  input  logic                ser_tx,
  output logic [NPINS-1:0]    pad_out,
  output logic [NPINS-1:0]    pad_oe,
  output logic [NPINS-1:0]    pad_pd_en,
  output logic                ser_rx,
  output logic [1:0]          ext_irq
);
  logic ser_on, irq_on;
  logic [NPINS-1:0] off_mask;

  assign ser_on   = ctl_q[CTL_SER];
  assign irq_on   = ctl_q[CTL_IRQ];
  assign off_mask = forced_off(ser_on, irq_on);

  always_comb begin
    pad_out = drv_q;
    pad_oe  = den_q & ~off_mask;
    if (ser_on) begin
      pad_out[TX_PIN] = ser_tx;
      pad_oe[TX_PIN]  = 1'b1;
    end
  end

  assign pad_pd_en = ~pdd_q;
  assign ser_rx    = ser_on ? lvl_sync[RX_PIN] : 1'b1;
  assign ext_irq   = irq_on ? lvl_sync[1:0] : 2'b00;
endmodule

// File: rtl/gpio_alt_bank.sv
module gpio_alt_bank
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [3:0]       pad_in,
  output logic [3:0]       pad_out,
  output logic [3:0]       pad_oe,
  output logic [3:0]       pad_pd_en,
  input  logic             ser_tx,
  output logic             ser_rx,
  output logic [1:0]       ext_irq
);
  logic [NPINS-1:0]    lvl_sync;
  logic [NPINS-1:0]    drv_q, den_q, pdd_q;
  logic [CTL_BITS-1:0] ctl_q;
  logic                ser_mode, irq_mode;

  assign ser_mode = ctl_q[CTL_SER];
  assign irq_mode = ctl_q[CTL_IRQ];

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_sync)
  );

  gpio_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .lvl_sync(lvl_sync), .rdata(bus_rdata),
    .drv_q(drv_q), .den_q(den_q), .pdd_q(pdd_q), .ctl_q(ctl_q)
  );

  gpio_pinmux u_mux (
    .drv_q(drv_q), .den_q(den_q), .pdd_q(pdd_q), .ctl_q(ctl_q),
    .lvl_sync(lvl_sync), .ser_tx(ser_tx), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pd_en(pad_pd_en), .ser_rx(ser_rx), .ext_irq(ext_irq)
  );

  assert_reset_tristate_R1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_pd_en == '1 && ext_irq == '0));

  assert_tx_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_mode |-> (pad_oe[TX_PIN] && pad_out[TX_PIN] == ser_tx && !pad_oe[RX_PIN]));

  assert_rx_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_mode |-> ser_rx);

  assert_irq_listen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mode |-> (pad_oe[1:0] == 2'b00 && ext_irq == lvl_sync[1:0]));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mode |-> ext_irq == 2'b00);

  assert_plain_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == '0) |-> (pad_oe == den_q));
endmodule

// File: tb/tb_gpio_alt_bank.sv
module tb_gpio_alt_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] pad_in = '0;
  logic [3:0] pad_out, pad_oe, pad_pd_en;
  logic       ser_tx = 1'b0;
  logic       ser_rx;
  logic [1:0] ext_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_alt_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pd_en(pad_pd_en), .ser_tx(ser_tx), .ser_rx(ser_rx), .ext_irq(ext_irq)
  );

  typedef struct packed {
    logic [1:0] ctl;
    logic [3:0] drv;
    logic [3:0] den;
    logic       tx;
    logic [3:0] exp_oe;
    logic [3:0] exp_out;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 4'h5, 4'hF, 1'b0, 4'hF, 4'h5},
    '{2'b00, 4'hA, 4'h3, 1'b0, 4'h3, 4'hA},
    '{2'b10, 4'h0, 4'hF, 1'b1, 4'h7, 4'h4},
    '{2'b01, 4'hF, 4'hF, 1'b0, 4'hC, 4'hF},
    '{2'b11, 4'hF, 4'hF, 1'b0, 4'h4, 4'hB},
    '{2'b11, 4'h0, 4'h0, 1'b1, 4'h4, 4'h4}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 oe in reset", {4'h0, pad_oe}, 8'h00);
    check("R1 pulldown in reset", {4'h0, pad_pd_en}, 8'h0F);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h20, r); check("R1 drive reg", r, 8'h00);
    rd(8'h21, r); check("R1 enable reg", r, 8'h00);
    rd(8'h05, r); check("R1 ctrl reg", r, 8'h00);
    check("R1 irq", {6'h0, ext_irq}, 8'h00);

    // Vector walk: R3 R7 R8 pin mux
    for (int i = 0; i < NVEC; i++) begin
      ser_tx = VECS[i].tx;
      wr(8'h20, {4'h0, VECS[i].drv});
      wr(8'h21, {4'h0, VECS[i].den});
      wr(8'h05, {6'h0, VECS[i].ctl});
      #1;
      check("R3/R7/R8 pad_oe", {4'h0, pad_oe}, {4'h0, VECS[i].exp_oe});
      check("R3/R7/R8 pad_out", {4'h0, pad_out}, {4'h0, VECS[i].exp_out});
    end
    // Toggle ser_tx under serial takeover (R7)
    @(negedge clk); ser_tx = 1'b0; #1;
    check("R7 tx follows", {7'h0, pad_out[2]}, 8'h00);

    // R9: writes during takeover land; readback unchanged
    wr(8'h20, 8'h69); wr(8'h21, 8'hF6);
    #1 check("R9 pad_oe override", {4'h0, pad_oe}, 8'h04);
    rd(8'h20, r); check("R9 drive readback", r, 8'h09);
    rd(8'h21, r); check("R9 enable readback", r, 8'h06);
    wr(8'h05, 8'h00);
    #1 check("R9 oe after release", {4'h0, pad_oe}, 8'h06);
    check("R3 out after release", {4'h0, pad_out}, 8'h09);

    // R2: reserved bits, ctrl width
    wr(8'h25, 8'hFF);
    rd(8'h25, r); check("R2 pdd reserved", r, 8'h0F);
    check("R4 all pulldown off", {4'h0, pad_pd_en}, 8'h00);
    wr(8'h25, 8'h05);
    #1 check("R4 pulldown mix", {4'h0, pad_pd_en}, 8'h0A);
    wr(8'h05, 8'hFC);
    rd(8'h05, r); check("R2 ctrl reserved", r, 8'h00);

    // R5: synchronized input, read-only
    @(negedge clk); pad_in = 4'hD;
    rd(8'h22, r); check("R5 not yet synced", r, 8'h00);
    @(negedge clk);
    #1 bus_addr = 8'h22;
    rd(8'h22, r); check("R5 synced level", r, 8'h0D);
    wr(8'h22, 8'h03);
    rd(8'h22, r); check("R5 write ignored level", r, 8'h0D);
    rd(8'h20, r); check("R5 write ignored drive", r, 8'h09);
    rd(8'h21, r); check("R5 write ignored enable", r, 8'h06);

    // R6: unmapped and idle
    rd(8'h23, r); check("R6 unmapped 23h", r, 8'h00);
    rd(8'hFF, r); check("R6 unmapped FFh", r, 8'h00);
    @(negedge clk); bus_addr = 8'h20; #1;
    check("R6 no strobe", bus_rdata, 8'h00);

    // R7/R8 receive paths with pad change during read
    check("R7 rx idle", {7'h0, ser_rx}, 8'h01);
    wr(8'h05, 8'h03);
    @(negedge clk); pad_in = 4'h6;
    @(negedge clk);
    @(negedge clk);
    #1 check("R8 irq levels", {6'h0, ext_irq}, 8'h02);
    check("R7 rx level", {7'h0, ser_rx}, 8'h00);
    rd(8'h22, r); check("R5 level with takeover", r, 8'h06);
    @(negedge clk); pad_in = 4'h9;
    repeat (2) @(negedge clk);
    #1 check("R8 irq new", {6'h0, ext_irq}, 8'h01);
    check("R7 rx high", {7'h0, ser_rx}, 8'h01);
    wr(8'h05, 8'h00);
    #1 check("R8 irq off", {6'h0, ext_irq}, 8'h00);

    // R1: reset again clears all
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 reset oe", {4'h0, pad_oe}, 8'h00);
    check("R1 reset pulldown", {4'h0, pad_pd_en}, 8'h0F);
    @(negedge clk); rst_n = 1'b1;
    rd(8'h25, r); check("R1 pdd after reset", r, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule